// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block watches 112 general-purpose input pins, arranged as four ports of 32, 32, 16 and 32 bits. It turns them into eight shared interrupt slots. Each slot has a 4-bit routing selector that picks one of sixteen candidate pins. It also has a 3-bit trigger code, a mask bit and an acknowledge bit. Every pin is first brought into the system clock domain by a two-flop synchroniser.

A slot in a level mode reports the present state of its pin. A slot in an edge mode sets a sticky latch, which stays set until software acknowledges it. The masked slot status is ORed into one registered interrupt line. Software configures the block through a small word-addressed register interface. Writes take effect on the next clock edge, and reads are combinational and have no side effects.

Top module: `gpio_group_irq`

## Requirements
- R1: After reset, the trigger-code, routing and mask registers all read 0 and `irq_o` is 0.
- R2: Register byte offsets are: trigger codes 120 (bits [3g+2:3g] for slot g, bits [31:24] read 0), routing 124 (bits [4g+3:4g]), mask 128 (bits [7:0], bits [31:8] read 0), acknowledge 132 (write only, reads 0) and masked status 140 (read only; bits [31:8] read 0). Any other offset reads 0, and writes to it are ignored. A write appears on reads from the next cycle onward.
- R3: A routing value r = 4p + k for slot g selects bit 8k + g of port p. Port p starts at bit 0, 32, 64 or 80 of `pins_i`, for p = 0 to 3. When that bit lies beyond the port's width (port 2 with k of 2 or 3), the slot sees a constant 0.
- R4: The level trigger codes are 1 (status equals the pin), 2 (status equals the inverted pin) and 3 (status is always 1). Codes 0 and 4 give a status of 0.
- R5: The edge trigger codes are 5 (rising), 6 (falling) and 7 (either). An edge on the selected synchronised pin, taken against its value one cycle earlier, sets a latch. The latch stays set while the pin is steady or changes back.
- R6: Writing to offset 132 clears the latch of each slot whose bit in wdata[7:0] is 1. Slots whose bit is 0 keep their latch.
- R7: When an acknowledge and a new edge reach the same slot in the same cycle, the latch stays set.
- R8: Offset 140 returns the raw slot status ANDed with the mask, one bit per slot.
- R9: `irq_o` is the OR of the eight masked-status bits, delayed by one register.
- R10: A pin change reaches a level-mode status after two clock edges and an edge-mode latch after three.
- R11: A slot whose trigger code is not an edge code has its latch cleared at the next edge. Changing back to an edge code therefore reports no stale event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 112 | Asynchronous pin inputs; port 0 at [31:0], 1 at [63:32], 2 at [79:64], 3 at [111:80] |
| wr_en_i | input | 1 | Register write strobe for one cycle |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
A pin change shows in a level-mode masked status after two rising edges and in an edge-mode latch after three. The interrupt line follows the masked status by one further edge. A register write shows on reads from the next cycle. The bench holds a behavioural model that it advances at each rising edge, with the same inputs the design sees. It compares the read port and the interrupt line at every falling edge. This way each result is checked in the exact cycle it is due. Directed checks sample the status at counted falling edges, to pin down the two-edge and three-edge latencies and the case where an acknowledge and an edge collide.

// File: rtl/gpio_grp_pkg.sv
package gpio_grp_pkg;
    localparam int GRP_N   = 8;
    localparam int MODE_W  = 3;
    localparam int ROUTE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        TRIG_OFF  = 3'd0,
        TRIG_HIGH = 3'd1,
        TRIG_LOW  = 3'd2,
        TRIG_ON   = 3'd3,
        TRIG_RISE = 3'd5,
        TRIG_FALL = 3'd6,
        TRIG_BOTH = 3'd7
    } trig_e;

    typedef struct packed {
        logic [GRP_N*MODE_W-1:0]  mode;
        logic [GRP_N*ROUTE_W-1:0] route;
        logic [GRP_N-1:0]         mask;
        logic                     irq;
    } ctl_regs_t;
endpackage

// File: rtl/gpio_grp_sync.sv
module gpio_grp_sync #(
    parameter int W = 112
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/gpio_grp_slot.sv
module gpio_grp_slot
    import gpio_grp_pkg::*;
#(
    parameter int SLOT = 0,
    parameter int P0_W = 32,
    parameter int P1_W = 32,
    parameter int P2_W = 16,
    parameter int P3_W = 32,
    localparam int TOTAL = P0_W + P1_W + P2_W + P3_W,
    localparam int IDX_W = $clog2(TOTAL)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [TOTAL-1:0]   pins_s_i,
    input  logic [ROUTE_W-1:0] route_i,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic               ack_i,
    output logic               raw_o
);
    typedef struct packed {
        logic prev;
        logic latch;
    } slot_t;

    slot_t st_d, st_q;
    logic  sel;
    logic  hit;
    logic  is_edge;

    // Pin selection: port = route[3:2], bank = route[1:0]
    always_comb begin
        int idx;
        int pos;
        logic ok;
        idx = 8 * int'(route_i[1:0]) + SLOT;
        unique case (route_i[3:2])
            2'd0:    begin ok = idx < P0_W; pos = idx; end
            2'd1:    begin ok = idx < P1_W; pos = P0_W + idx; end
            2'd2:    begin ok = idx < P2_W; pos = P0_W + P1_W + idx; end
            default: begin ok = idx < P3_W; pos = P0_W + P1_W + P2_W + idx; end
        endcase
        if (pos >= TOTAL) pos = 0;
        sel = ok ? pins_s_i[IDX_W'(pos)] : 1'b0;
    end

    always_comb begin
        is_edge = 1'b0;
        hit     = 1'b0;
        raw_o   = 1'b0;
        unique case (mode_i)
            TRIG_HIGH: raw_o = sel;
            TRIG_LOW:  raw_o = ~sel;
            TRIG_ON:   raw_o = 1'b1;
            TRIG_RISE: begin is_edge = 1'b1; hit = sel & ~st_q.prev; raw_o = st_q.latch; end
            TRIG_FALL: begin is_edge = 1'b1; hit = ~sel & st_q.prev; raw_o = st_q.latch; end
            TRIG_BOTH: begin is_edge = 1'b1; hit = sel ^ st_q.prev;  raw_o = st_q.latch; end
            default:   raw_o = 1'b0;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.prev  = sel;
        st_d.latch = is_edge & (hit | (st_q.latch & ~ack_i));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R5: an armed latch holds while no acknowledge arrives
    a_r5_latch_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.latch && is_edge && !ack_i) |=> st_q.latch);
    // R7: a fresh edge keeps the latch set even with an acknowledge
    a_r7_edge_beats_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_edge && hit && ack_i) |=> st_q.latch);
    // R6: an acknowledge without a new edge empties the latch
    a_r6_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && !hit) |=> !st_q.latch);
    // R11: a non-edge trigger code leaves no latch behind
    a_r11_nonedge_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !is_edge |=> !st_q.latch);
endmodule

// File: rtl/gpio_group_irq.sv
module gpio_group_irq
    import gpio_grp_pkg::*;
#(
    parameter int P0_W      = 32,
    parameter int P1_W      = 32,
    parameter int P2_W      = 16,
    parameter int P3_W      = 32,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int OFF_MODE  = 120,
    parameter int OFF_ROUTE = 124,
    parameter int OFF_MASK  = 128,
    parameter int OFF_ACK   = 132,
    parameter int OFF_STAT  = 140,
    localparam int TOTAL    = P0_W + P1_W + P2_W + P3_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [TOTAL-1:0]  pins_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    localparam int MODE_BITS  = GRP_N * MODE_W;
    localparam int ROUTE_BITS = GRP_N * ROUTE_W;

    ctl_regs_t        st_d, st_q;
    logic [TOTAL-1:0] pins_s;
    logic [GRP_N-1:0] raw;
    logic [GRP_N-1:0] masked;
    logic [GRP_N-1:0] ack;

    gpio_grp_sync #(.W(TOTAL)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pins_i),
        .sync_o  (pins_s)
    );

    assign ack = (wr_en_i && addr_i == ADDR_W'(OFF_ACK)) ? wdata_i[GRP_N-1:0] : '0;

    for (genvar g = 0; g < GRP_N; g++) begin : g_slot
        gpio_grp_slot #(
            .SLOT (g),
            .P0_W (P0_W),
            .P1_W (P1_W),
            .P2_W (P2_W),
            .P3_W (P3_W)
        ) u_slot (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .pins_s_i (pins_s),
            .route_i  (st_q.route[ROUTE_W*g +: ROUTE_W]),
            .mode_i   (st_q.mode[MODE_W*g +: MODE_W]),
            .ack_i    (ack[g]),
            .raw_o    (raw[g])
        );
    end

    assign masked = raw & st_q.mask;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |masked;
        if (wr_en_i) begin
            if (addr_i == ADDR_W'(OFF_MODE))  st_d.mode  = wdata_i[MODE_BITS-1:0];
            if (addr_i == ADDR_W'(OFF_ROUTE)) st_d.route = wdata_i[ROUTE_BITS-1:0];
            if (addr_i == ADDR_W'(OFF_MASK))  st_d.mask  = wdata_i[GRP_N-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if      (addr_i == ADDR_W'(OFF_MODE))  rdata_o = DATA_W'(st_q.mode);
        else if (addr_i == ADDR_W'(OFF_ROUTE)) rdata_o = DATA_W'(st_q.route);
        else if (addr_i == ADDR_W'(OFF_MASK))  rdata_o = DATA_W'(st_q.mask);
        else if (addr_i == ADDR_W'(OFF_STAT))  rdata_o = DATA_W'(masked);
    end

    assign irq_o = st_q.irq;

    // R9: the interrupt line follows the masked status one edge later
    a_r9_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|masked) |=> irq_o);
    a_r9_irq_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|masked) |=> !irq_o);
    // R2: a mask write appears on the next cycle
    a_r2_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == ADDR_W'(OFF_MASK)) |=> st_q.mask == $past(wdata_i[GRP_N-1:0]));
    // R2: without a write the trigger codes hold
    a_r2_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && addr_i == ADDR_W'(OFF_MODE)) |=> $stable(st_q.mode));
endmodule

// File: tb/tb_gpio_group_irq.sv
module tb_gpio_group_irq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [111:0] pins = '0;
    logic         wr_en = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gpio_group_irq dut (
        .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    // ---------------- behavioural reference ----------------
    logic [111:0] m_s1, m_s2;
    logic [7:0]   m_prev, m_latch, m_mask;
    logic [23:0]  m_mode;
    logic [31:0]  m_route;
    logic         m_irq;

    function automatic logic pick(int g, logic [111:0] s, logic [31:0] rt);
        int p, k, idx, w, b;
        p = int'(rt[4*g+2 +: 2]);
        k = int'(rt[4*g +: 2]);
        idx = 8 * k + g;
        case (p)
            0: begin w = 32; b = 0;  end
            1: begin w = 32; b = 32; end
            2: begin w = 16; b = 64; end
            default: begin w = 32; b = 80; end
        endcase
        return (idx < w) ? s[b + idx] : 1'b0;
    endfunction

    function automatic logic [7:0] model_raw();
        logic [7:0] r;
        for (int g = 0; g < 8; g++) begin
            int md;
            logic v;
            md = int'(m_mode[3*g +: 3]);
            v = pick(g, m_s2, m_route);
            case (md)
                1: r[g] = v;
                2: r[g] = !v;
                3: r[g] = 1'b1;
                5, 6, 7: r[g] = m_latch[g];
                default: r[g] = 1'b0;
            endcase
        end
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_latch = '0;
            m_mask = '0; m_mode = '0; m_route = '0; m_irq = 1'b0;
        end else begin
            logic [7:0] n_prev, n_latch, rw;
            rw = model_raw();
            for (int g = 0; g < 8; g++) begin
                int md;
                logic v, h, ak;
                md = int'(m_mode[3*g +: 3]);
                v = pick(g, m_s2, m_route);
                h = (md == 5 && v && !m_prev[g]) || (md == 6 && !v && m_prev[g]) ||
                    (md == 7 && v != m_prev[g]);
                ak = wr_en && addr == 8'd132 && wdata[g];
                n_latch[g] = (md >= 5) && (h || (m_latch[g] && !ak));
                n_prev[g] = v;
            end
            m_irq = |(rw & m_mask);
            m_latch = n_latch;
            m_prev = n_prev;
            m_s2 = m_s1;
            m_s1 = pins;
            if (wr_en) begin
                if (addr == 8'd120) m_mode = wdata[23:0];
                if (addr == 8'd124) m_route = wdata;
                if (addr == 8'd128) m_mask = wdata[7:0];
            end
        end
    end

    function automatic logic [31:0] model_rd(logic [7:0] a);
        case (a)
            8'd120: return {8'h0, m_mode};
            8'd124: return m_route;
            8'd128: return {24'h0, m_mask};
            8'd140: return {24'h0, model_raw() & m_mask};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9", {31'h0, irq}, {31'h0, m_irq});
            chk((addr == 8'd140) ? "R8" : "R2", rdata, model_rd(addr));
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        step();
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0; addr = 8'd140;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
        addr = a; #1;
        chk(req, rdata, exp);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        step();
        // R1 reset state
        rd_chk("R1", 8'd120, 32'h0);
        rd_chk("R1", 8'd124, 32'h0);
        rd_chk("R1", 8'd128, 32'h0);
        chk("R1", {31'h0, irq}, 32'h0);

        // R2 register readback and widths
        wr(8'd120, 32'hFFFF_FFFF);
        rd_chk("R2", 8'd120, 32'h00FF_FFFF);
        wr(8'd128, 32'hFFFF_FF5A);
        rd_chk("R2", 8'd128, 32'h0000_005A);
        wr(8'd124, 32'hDEAD_BEEF);
        rd_chk("R2", 8'd124, 32'hDEAD_BEEF);
        wr(8'd140, 32'hFFFF_FFFF);
        rd_chk("R2", 8'd132, 32'h0);
        rd_chk("R2", 8'd64, 32'h0);
        wr(8'd120, 32'h0);
        wr(8'd124, 32'h0);
        wr(8'd128, 32'hFF);

        // R3 routing: slot 3 <- port 1 bank 2 = pins[32+19]
        wr(8'd124, 32'h0000_6000);
        wr(8'd120, 32'h0000_0200);   // slot 3 level high
        pins[51] = 1'b1;
        idle(4);
        rd_chk("R3", 8'd140, 32'h08);
        // port 2 bank 3 is out of range: constant 0 though pins[91] high
        pins[91] = 1'b1;
        wr(8'd124, 32'h0000_B000);
        idle(4);
        rd_chk("R3", 8'd140, 32'h00);
        pins[51] = 1'b0; pins[91] = 1'b0;
        wr(8'd124, 32'h0);
        wr(8'd120, 32'h0);

        // R4 level codes on slot 0, pin 0 low
        wr(8'd120, 32'h2);
        idle(3);
        rd_chk("R4", 8'd140, 32'h01);
        wr(8'd120, 32'h3);
        rd_chk("R4", 8'd140, 32'h01);
        wr(8'd120, 32'h4);
        rd_chk("R4", 8'd140, 32'h00);
        wr(8'd120, 32'h0);
        rd_chk("R4", 8'd140, 32'h00);

        // R5 edges: slot 1 rising (pin 1), slot 2 falling (pin 2)
        pins[2] = 1'b1;
        idle(4);
        wr(8'd120, (32'd5 << 3) | (32'd6 << 6));
        idle(3);
        rd_chk("R5", 8'd140, 32'h00);
        pins[1] = 1'b1;
        idle(4);
        rd_chk("R5", 8'd140, 32'h02);
        pins[1] = 1'b0; pins[2] = 1'b0;
        idle(4);
        rd_chk("R5", 8'd140, 32'h06);

        // R6 acknowledge: zero bits have no effect, then clear slot 1 only
        wr(8'd132, 32'h0);
        rd_chk("R6", 8'd140, 32'h06);
        wr(8'd132, 32'h2);
        rd_chk("R6", 8'd140, 32'h04);
        wr(8'd132, 32'h4);
        rd_chk("R6", 8'd140, 32'h00);

        // R7 edge and acknowledge in the same cycle on slot 1 (either-edge)
        wr(8'd120, 32'd7 << 3);
        idle(2);
        pins[1] = 1'b1;
        idle(4);
        rd_chk("R7", 8'd140, 32'h02);
        pins[1] = 1'b0;          // after this: edge 1 s1, edge 2 s2, edge 3 latch
        step();
        step();
        wr_en = 1'b1; addr = 8'd132; wdata = 32'h2;
        step();
        wr_en = 1'b0;
        rd_chk("R7", 8'd140, 32'h02);

        // R11 leaving edge mode drops the latch
        wr(8'd120, 32'd1 << 3);
        wr(8'd120, 32'd7 << 3);
        rd_chk("R11", 8'd140, 32'h00);

        // R9 masking and the interrupt line
        wr(8'd120, 32'd3 << 21);   // slot 7 always set
        wr(8'd128, 32'h00);
        idle(2);
        chk("R9", {31'h0, irq}, 32'h0);
        rd_chk("R8", 8'd140, 32'h00);
        wr(8'd128, 32'h80);
        rd_chk("R8", 8'd140, 32'h80);
        step();
        chk("R9", {31'h0, irq}, 32'h1);
        wr(8'd120, 32'h0);
        idle(2);

        // R10 latency: level high slot 0 on pin 0
        wr(8'd128, 32'h01);
        wr(8'd120, 32'h1);
        addr = 8'd140;
        pins[0] = 1'b1;
        step();
        rd_chk("R10", 8'd140, 32'h00);
        step();
        rd_chk("R10", 8'd140, 32'h01);
        chk("R10", {31'h0, irq}, 32'h0);
        step();
        chk("R10", {31'h0, irq}, 32'h1);
        // edge latency: rising on slot 0
        wr(8'd120, 32'h5);
        pins[0] = 1'b0;
        idle(4);
        pins[0] = 1'b1;
        step();
        step();
        rd_chk("R10", 8'd140, 32'h00);
        step();
        rd_chk("R10", 8'd140, 32'h01);

        // mixed pattern sweep, model-compared every cycle
        wr(8'd128, 32'hFF);
        wr(8'd124, 32'h7654_3210);
        wr(8'd120, 32'h00FB_5A39);
        for (int i = 0; i < 300; i++) begin
            pins = {pins[110:0], pins[111] ^ pins[97] ^ pins[3] ^ 1'b1};
            if (i % 37 == 0) begin
                wr_en = 1'b1; addr = 8'd132; wdata = 32'h55;
            end else begin
                wr_en = 1'b0; addr = 8'd140;
            end
            step();
        end
        wr_en = 1'b0;
        idle(3);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule